// File: doc/BRIEF.md
# Quad SPI Flash Read Sequencer

This block sits between a pipelined 32-bit word-addressed read port and a lower-level serial shift engine that drives a quad-capable SPI flash. Each accepted read becomes a short series of engine commands. A command gives a number of flash clocks, the lane width (one line or four), whether input is captured, the bits to shift out MSB first, and whether chip select is released when the command ends. The sequencer chooses between a single-line fast read and a quad I/O read from the `quad_en` level sampled when the request is accepted.

After a quad read header the flash is left in continuous-read mode, so a later quad read can skip the opcode. After each word, chip select stays asserted and the engine's clock is parked. A request for the next word in the same mode then costs only one data command. Chip select is released on a non-sequential address, on a change of mode, on an exit request, or after `IDLE_LIMIT` idle cycles. `exit_req` forces the flash out of continuous mode before other kinds of command are sent to it. The same exit is performed on its own when a single-line read is requested while continuous mode is active.

Top module: `rsq_read_seq`

## Requirements
- R1: The returned word is little-endian. The first byte clocked out of the flash appears on `rd_data[7:0]` and the fourth on `rd_data[31:24]`.
- R2: A single-line read from a closed stream issues three commands. The first is a 32-clock command carrying opcode 0x0B in bits 31:24 and the byte address (word address times 4) in bits 23:0. The second is an 8-clock dummy. The third is a 32-clock capture. The total is 72 flash clocks.
- R3: A quad read with continuous mode clear issues four commands. The first is an 8-clock single-line command with 0xEB in bits 31:24. The second is an 8-clock quad command carrying the byte address in bits 31:8 and 0xA0 in bits 7:0. The third is a 4-clock quad dummy and the fourth an 8-clock quad capture, for 28 clocks in all. A command is held stable until the engine takes it.
- R4: A quad read that starts while continuous mode is set omits the opcode and costs 20 flash clocks.
- R5: While a stream is open, a request for the next word address in the same mode is served by one capture command (32 clocks single-line, 8 clocks quad), and chip select is not released.
- R6: A non-sequential address, a change of `quad_en`, or `IDLE_LIMIT` cycles without a request ends an open stream. The end is a release command (0 clocks, `cmd_last`=1), and it is issued before any new header.
- R7: While continuous mode is set, `exit_req`, or a single-line read request, triggers an exit command: 32 single-line clocks of all ones with release. Exit clears continuous mode, so the next quad read costs 28 clocks. `req_stall` is high while `exit_req` is pending.
- R8: Exactly one `rd_ack` pulse with data follows each accepted read, and only after the engine's response. `req_stall` is high while a read is in flight.
- R9: After reset, `req_stall`, `rd_ack` and `cmd_valid` are low and continuous mode is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_stb | input | 1 | Read request strobe |
| req_addr | input | AW | Word address of the request |
| quad_en | input | 1 | Use quad I/O reads when high |
| exit_req | input | 1 | Leave continuous-read mode |
| req_stall | output | 1 | Request cannot be accepted this cycle |
| rd_ack | output | 1 | Read data valid, one pulse per read |
| rd_data | output | 32 | Read data word |
| cmd_valid | output | 1 | Engine command valid |
| cmd_ready | input | 1 | Engine accepts a command |
| cmd_bits | output | 6 | Flash clocks in the command (0 = release only) |
| cmd_quad | output | 1 | Use four lanes |
| cmd_rd | output | 1 | Capture input data |
| cmd_wdata | output | 32 | Bits to shift out, MSB first |
| cmd_last | output | 1 | Release chip select at the end |
| rsp_valid | input | 1 | Captured word from the engine |
| rsp_data | input | 32 | Captured bits, first received in the MSBs |

## Verification
The bench models the engine and the flash contents. For every read it counts the flash clocks and chip-select releases spent since the previous one, so a sequencer that keeps a stream open across a jump, reissues the opcode while continuous mode is set, or skips it after an exit shows up as a wrong clock count. The sequences that mix modes are the sharpest cases. One is a single-line read while continuous mode is still active, which must cost 104 clocks, including the exit. Another is a quad request that arrives while a single-line stream is open. A wrong header address or a byte swap corrupts the returned data. A request issued while a read is in flight must see stall and still receive exactly one acknowledge.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_EXIT, ST_OPC, ST_ADDR, ST_DUMMY,
      ST_DATA, ST_WAIT, ST_STREAM, ST_CLOSE
   } rsq_state_e;

   localparam logic [7:0] OP_FAST_SER = 8'h0B;
   localparam logic [7:0] OP_QUAD_IO  = 8'hEB;
   localparam logic [7:0] CONT_KEEP   = 8'hA0;
   localparam int         BITS_W      = 6;
   localparam int         WORD_W      = 32;
endpackage

// File: rtl/rsq_addr_track.sv
module rsq_addr_track #(
   parameter int AW         = 22,
   parameter int IDLE_LIMIT = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] addr_in,
   input  logic          run,
   output logic [AW-1:0] cur_addr,
   output logic          seq_hit,
   output logic          idle_expired
);
   localparam int CW = $clog2(IDLE_LIMIT + 1);

   logic [CW-1:0] idle_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
         idle_cnt <= '0;
      end else begin
         if (load)
            cur_addr <= addr_in;
         if (!run)
            idle_cnt <= '0;
         else if (idle_cnt != CW'(IDLE_LIMIT))
            idle_cnt <= idle_cnt + 1'b1;
      end
   end

   assign seq_hit      = (addr_in == cur_addr + AW'(1));
   assign idle_expired = (idle_cnt == CW'(IDLE_LIMIT));
endmodule

// File: rtl/rsq_cmd_fmt.sv
module rsq_cmd_fmt
   import rsq_pkg::*;
#(
   parameter int AW         = 22,
   parameter int SER_DUMMY  = 8,
   parameter int QUAD_DUMMY = 4
) (
   input  rsq_state_e          st,
   input  logic                q_path,
   input  logic [AW-1:0]       addr,
   output logic                valid,
   output logic [BITS_W-1:0]   bits,
   output logic                quad,
   output logic                rd,
   output logic [WORD_W-1:0]   wdata,
   output logic                last
);
   localparam int BA_W = AW + 2;

   logic [23:0] byte_addr;

   always_comb begin
      byte_addr             = '0;
      byte_addr[BA_W-1:0]   = {addr, 2'b00};
   end

   always_comb begin
      valid = 1'b1;
      bits  = '0;
      quad  = 1'b0;
      rd    = 1'b0;
      wdata = '0;
      last  = 1'b0;
      case (st)
         ST_EXIT: begin
            bits  = BITS_W'(32);
            wdata = '1;
            last  = 1'b1;
         end
         ST_OPC: begin
            if (q_path) begin
               bits  = BITS_W'(8);
               wdata = {OP_QUAD_IO, 24'h0};
            end else begin
               bits  = BITS_W'(32);
               wdata = {OP_FAST_SER, byte_addr};
            end
         end
         ST_ADDR: begin
            bits  = BITS_W'(8);
            quad  = 1'b1;
            wdata = {byte_addr, CONT_KEEP};
         end
         ST_DUMMY: begin
            quad = q_path;
            bits = q_path ? BITS_W'(QUAD_DUMMY) : BITS_W'(SER_DUMMY);
         end
         ST_DATA: begin
            rd   = 1'b1;
            quad = q_path;
            bits = q_path ? BITS_W'(8) : BITS_W'(32);
         end
         ST_CLOSE: begin
            last = 1'b1;
         end
         default: valid = 1'b0;
      endcase
   end
endmodule

// File: rtl/rsq_word_pack.sv
module rsq_word_pack #(
   parameter bit FIRST_BYTE_LOW = 1'b1
) (
   input  logic [31:0] raw,
   output logic [31:0] word
);
   generate
      if (FIRST_BYTE_LOW) begin : g_swap
         for (genvar b = 0; b < 4; b++) begin : g_byte
            assign word[8*b +: 8] = raw[8*(3-b) +: 8];
         end
      end else begin : g_pass
         assign word = raw;
      end
   endgenerate
endmodule

// File: rtl/rsq_read_seq.sv
module rsq_read_seq
   import rsq_pkg::*;
#(
   parameter int AW             = 22,
   parameter int IDLE_LIMIT     = 16,
   parameter int SER_DUMMY      = 8,
   parameter int QUAD_DUMMY     = 4,
   parameter bit FIRST_BYTE_LOW = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_stb,
   input  logic [AW-1:0] req_addr,
   input  logic          quad_en,
   input  logic          exit_req,
   output logic          req_stall,
   output logic          rd_ack,
   output logic [31:0]   rd_data,
   output logic          cmd_valid,
   input  logic          cmd_ready,
   output logic [5:0]    cmd_bits,
   output logic          cmd_quad,
   output logic          cmd_rd,
   output logic [31:0]   cmd_wdata,
   output logic          cmd_last,
   input  logic          rsp_valid,
   input  logic [31:0]   rsp_data
);
   generate
      if (AW < 1 || AW + 2 > 24) begin : g_bad_aw
         $error("rsq_read_seq: AW must give a byte address of at most 24 bits");
      end
      if (IDLE_LIMIT < 1) begin : g_bad_idle
         $error("rsq_read_seq: IDLE_LIMIT must be at least 1");
      end
      if (SER_DUMMY < 1 || SER_DUMMY > 32 || QUAD_DUMMY < 1 || QUAD_DUMMY > 32) begin : g_bad_dummy
         $error("rsq_read_seq: dummy counts must lie in 1..32");
      end
   endgenerate

   rsq_state_e    st;
   logic          q_path;
   logic          cont;
   logic          pend;
   logic          accept;
   logic          fire;
   logic [AW-1:0] cur_addr;
   logic          seq_hit;
   logic          idle_expired;
   logic [31:0]   packed_word;

   // Stall and accept
   always_comb begin
      case (st)
         ST_IDLE:   req_stall = cont && exit_req;
         ST_STREAM: req_stall = exit_req;
         default:   req_stall = 1'b1;
      endcase
   end

   assign accept = req_stb && !req_stall;
   assign fire   = cmd_valid && cmd_ready;

   function automatic rsq_state_e route(input logic qp, input logic c);
      if (qp)
         return c ? ST_ADDR : ST_OPC;
      else
         return c ? ST_EXIT : ST_OPC;
   endfunction

   rsq_addr_track #(.AW(AW), .IDLE_LIMIT(IDLE_LIMIT)) u_track (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (accept),
      .addr_in      (req_addr),
      .run          ((st == ST_STREAM) && !accept),
      .cur_addr     (cur_addr),
      .seq_hit      (seq_hit),
      .idle_expired (idle_expired)
   );

   rsq_cmd_fmt #(.AW(AW), .SER_DUMMY(SER_DUMMY), .QUAD_DUMMY(QUAD_DUMMY)) u_fmt (
      .st     (st),
      .q_path (q_path),
      .addr   (cur_addr),
      .valid  (cmd_valid),
      .bits   (cmd_bits),
      .quad   (cmd_quad),
      .rd     (cmd_rd),
      .wdata  (cmd_wdata),
      .last   (cmd_last)
   );

   rsq_word_pack #(.FIRST_BYTE_LOW(FIRST_BYTE_LOW)) u_pack (
      .raw  (rsp_data),
      .word (packed_word)
   );

   // Sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         q_path  <= 1'b0;
         cont    <= 1'b0;
         pend    <= 1'b0;
         rd_ack  <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_ack <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (cont && exit_req) begin
                  pend <= 1'b0;
                  st   <= ST_EXIT;
               end else if (req_stb) begin
                  pend   <= 1'b1;
                  q_path <= quad_en;
                  st     <= route(quad_en, cont);
               end
            end
            ST_EXIT: if (fire) begin
               cont <= 1'b0;
               pend <= 1'b0;
               st   <= pend ? ST_OPC : ST_IDLE;
            end
            ST_OPC:   if (fire) st <= q_path ? ST_ADDR : ST_DUMMY;
            ST_ADDR:  if (fire) begin
               cont <= 1'b1;
               st   <= ST_DUMMY;
            end
            ST_DUMMY: if (fire) st <= ST_DATA;
            ST_DATA:  if (fire) st <= ST_WAIT;
            ST_WAIT:  if (rsp_valid) begin
               rd_ack  <= 1'b1;
               rd_data <= packed_word;
               st      <= ST_STREAM;
            end
            ST_STREAM: begin
               if (exit_req) begin
                  pend <= 1'b0;
                  st   <= ST_CLOSE;
               end else if (req_stb) begin
                  if (seq_hit && (quad_en == q_path)) begin
                     st <= ST_DATA;
                  end else begin
                     pend   <= 1'b1;
                     q_path <= quad_en;
                     st     <= ST_CLOSE;
                  end
               end else if (idle_expired) begin
                  pend <= 1'b0;
                  st   <= ST_CLOSE;
               end
            end
            ST_CLOSE: if (fire) st <= pend ? route(q_path, cont) : ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // Checks
   AST_ACK_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack |-> $past(rsp_valid)); // R8
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack |=> !rd_ack); // R8
   AST_STALL_WHILE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> req_stall); // R8
   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_bits) && $stable(cmd_wdata)); // R3
   AST_SER_DATA_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_rd && !cmd_quad |-> cmd_bits == 6'd32); // R2
   AST_QUAD_DATA_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_rd && cmd_quad |-> cmd_bits == 6'd8); // R5
   AST_EXIT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_last && cmd_bits != 6'd0 |->
         !cmd_quad && cmd_bits == 6'd32 && cmd_wdata == 32'hFFFF_FFFF); // R7
endmodule

// File: tb/rsq_read_seq_bench.sv
module rsq_read_seq_bench;
   localparam int PERIOD = 10;
   localparam int AW     = 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_stb = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          quad_en = 1'b0;
   logic          exit_req = 1'b0;
   logic          req_stall;
   logic          rd_ack;
   logic [31:0]   rd_data;
   logic          cmd_valid;
   logic          cmd_ready;
   logic [5:0]    cmd_bits;
   logic          cmd_quad;
   logic          cmd_rd;
   logic [31:0]   cmd_wdata;
   logic          cmd_last;
   logic          rsp_valid = 1'b0;
   logic [31:0]   rsp_data = '0;

   always #(PERIOD/2) clk = ~clk;

   rsq_read_seq u_rsq_read_seq (
      .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .req_addr(req_addr),
      .quad_en(quad_en), .exit_req(exit_req), .req_stall(req_stall),
      .rd_ack(rd_ack), .rd_data(rd_data), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_bits(cmd_bits), .cmd_quad(cmd_quad),
      .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata), .cmd_last(cmd_last),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   int total = 0;
   int bad   = 0;

   // Flash content model
   function automatic logic [7:0] fbyte(input logic [23:0] b);
      return b[7:0] ^ b[15:8] ^ {b[19:16], b[23:20]} ^ 8'hA5;
   endfunction

   function automatic logic [31:0] exp_word(input logic [AW-1:0] a);
      logic [23:0] b;
      b = 24'({a, 2'b00});
      return {fbyte(b + 24'd3), fbyte(b + 24'd2), fbyte(b + 24'd1), fbyte(b)};
   endfunction

   // Engine model
   int          eng_clk = 0;
   int          eng_rel = 0;
   int          eng_exit = 0;
   logic [6:0]  busy = '0;
   logic        is_rd = 1'b0;
   logic [23:0] ptr = '0;
   logic [31:0] rd_word = '0;

   assign cmd_ready = (busy == 7'd0);

   always @(posedge clk) begin
      rsp_valid <= 1'b0;
      if (cmd_valid && cmd_ready) begin
         eng_clk <= eng_clk + int'(cmd_bits);
         if (cmd_bits == 6'd0 && cmd_last) eng_rel <= eng_rel + 1;
         if (cmd_bits == 6'd32 && !cmd_quad && cmd_last && cmd_wdata == 32'hFFFF_FFFF)
            eng_exit <= eng_exit + 1;
         busy  <= (cmd_bits == 6'd0) ? 7'd1 : {1'b0, cmd_bits};
         is_rd <= cmd_rd;
         if (cmd_rd) begin
            rd_word <= {fbyte(ptr), fbyte(ptr + 24'd1), fbyte(ptr + 24'd2), fbyte(ptr + 24'd3)};
            ptr     <= ptr + 24'd4;
         end else if (!cmd_quad && cmd_bits == 6'd32 && cmd_wdata[31:24] == 8'h0B) begin
            ptr <= cmd_wdata[23:0];
         end else if (cmd_quad && cmd_bits == 6'd8) begin
            ptr <= cmd_wdata[31:8];
         end
      end else if (busy != 7'd0) begin
         busy <= busy - 7'd1;
         if (busy == 7'd1 && is_rd) begin
            rsp_valid <= 1'b1;
            rsp_data  <= rd_word;
         end
      end
   end

   // Ack monitor
   int          ack_cnt = 0;
   logic [31:0] ack_data [64];
   always @(negedge clk) begin
      if (rd_ack) begin
         ack_data[ack_cnt % 64] = rd_data;
         ack_cnt = ack_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   int issued = 0;
   int clk_base = 0;
   int rel_base = 0;

   task automatic issue(input logic q, input logic [AW-1:0] a);
      @(negedge clk);
      quad_en  = q;
      req_addr = a;
      req_stb  = 1'b1;
      while (req_stall) @(negedge clk);
      @(negedge clk);
      req_stb = 1'b0;
      issued++;
   endtask

   task automatic wait_acks(input int n);
      int guard = 0;
      while (ack_cnt < n && guard < 3000) begin
         @(negedge clk);
         guard++;
      end
      if (ack_cnt < n) chk(1'b0, "R8 ack timeout", ack_cnt, n);
   endtask

   task automatic snap();
      clk_base = eng_clk;
      rel_base = eng_rel;
   endtask

   // {quad, addr, gap, clocks, releases, req}
   localparam int NV = 10;
   localparam logic [51:0] VEC [NV] = '{
      52'h0_000100_00_48_0_2, // R2 full single-line read
      52'h0_000101_00_20_0_5, // R5 stream single-line
      52'h0_000102_00_20_0_5, // R5
      52'h0_000200_00_48_1_6, // R6 jump closes, new header
      52'h1_000201_00_1C_1_3, // R3 mode change, quad with opcode
      52'h1_000202_00_08_0_5, // R5 quad stream
      52'h1_000203_28_14_1_4, // R4 idle close, opcode-less re-entry
      52'h1_000050_00_14_1_6, // R6 jump in quad, re-entry
      52'h0_000051_00_68_1_7, // R7 single-line while continuous: exit first
      52'h0_000052_00_20_0_5  // R5
   };

   initial begin
      #(PERIOD * 150000);
      chk(1'b0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!req_stall && !rd_ack && !cmd_valid, "R9 outputs in reset", {req_stall, rd_ack, cmd_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!req_stall && !rd_ack && !cmd_valid, "R9 outputs after reset", {req_stall, rd_ack, cmd_valid}, 0);
      snap();

      for (int i = 0; i < NV; i++) begin
         logic          q;
         logic [AW-1:0] a;
         int            gap, clks, rels, req;
         q    = VEC[i][48];
         a    = AW'(VEC[i][47:24]);
         gap  = int'(VEC[i][23:16]);
         clks = int'(VEC[i][15:8]);
         rels = int'(VEC[i][7:4]);
         req  = int'(VEC[i][3:0]);
         repeat (gap) @(negedge clk);
         issue(q, a);
         wait_acks(issued);
         chk(ack_data[(ack_cnt-1) % 64] == exp_word(a), $sformatf("R1 data vec %0d", i),
             ack_data[(ack_cnt-1) % 64], exp_word(a));
         chk(eng_clk - clk_base == clks, $sformatf("R%0d clocks vec %0d", req, i),
             eng_clk - clk_base, clks);
         chk(eng_rel - rel_base == rels, $sformatf("R6 releases vec %0d", i),
             eng_rel - rel_base, rels);
         snap();
      end

      // Quad from a single-line stream, then an explicit exit
      issue(1'b1, AW'(22'h300));
      wait_acks(issued);
      chk(eng_clk - clk_base == 28, "R3 quad after single-line stream", eng_clk - clk_base, 28);
      repeat (40) @(negedge clk);
      @(negedge clk);
      exit_req = 1'b1;
      @(negedge clk);
      chk(req_stall == 1'b1, "R7 stall during exit", req_stall, 1);
      begin
         int guard = 0;
         while (eng_exit < 2 && guard < 200) begin
            @(negedge clk);
            guard++;
         end
      end
      exit_req = 1'b0;
      chk(eng_exit == 2, "R7 exit command issued", eng_exit, 2);
      repeat (40) @(negedge clk);
      snap();
      issue(1'b1, AW'(22'h301));
      wait_acks(issued);
      chk(eng_clk - clk_base == 28, "R7 opcode resent after exit", eng_clk - clk_base, 28);
      chk(ack_data[(ack_cnt-1) % 64] == exp_word(AW'(22'h301)), "R1 data after exit",
          ack_data[(ack_cnt-1) % 64], exp_word(AW'(22'h301)));
      snap();

      // Pipelined: second request arrives while the first is in flight
      begin
         bit saw_stall;
         issue(1'b1, AW'(22'h302));
         @(negedge clk);
         quad_en  = 1'b1;
         req_addr = AW'(22'h303);
         req_stb  = 1'b1;
         saw_stall = req_stall;
         while (req_stall) @(negedge clk);
         @(negedge clk);
         req_stb = 1'b0;
         issued++;
         wait_acks(issued);
         chk(saw_stall, "R8 stall while read in flight", saw_stall, 1);
         chk(ack_data[(ack_cnt-2) % 64] == exp_word(AW'(22'h302)), "R1 pipelined first",
             ack_data[(ack_cnt-2) % 64], exp_word(AW'(22'h302)));
         chk(ack_data[(ack_cnt-1) % 64] == exp_word(AW'(22'h303)), "R1 pipelined second",
             ack_data[(ack_cnt-1) % 64], exp_word(AW'(22'h303)));
         chk(eng_clk - clk_base == 16, "R5 two streamed quad words", eng_clk - clk_base, 16);
         chk(eng_rel - rel_base == 0, "R5 no release while streaming", eng_rel - rel_base, 0);
      end

      repeat (30) @(negedge clk);
      chk(ack_cnt == issued, "R8 one ack per read", ack_cnt, issued);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule